// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves outgoing frames from memory to a byte stream. Software builds descriptors in a ring in memory. It sets the ownership flag in each one and then writes a start bit to a poll register. The engine fetches each owned descriptor through a request/acknowledge memory port and reads the buffer that the descriptor points to. It sends the buffer bytes out on a valid/ready byte interface. It then writes the status word back with the ownership flag cleared, so software can poll that flag to see that the descriptor is done.

The engine keeps walking the ring as long as it finds owned descriptors. At a descriptor marked end-of-ring it wraps back to the ring base. When it meets a descriptor it does not own, it raises a "nothing to send" status bit and waits for the next poll. Interrupt status bits report good completion, rejected descriptors and the empty ring. Each status bit is cleared by writing a one to it.

The byte output follows valid/ready rules. A byte is taken on a cycle where both `tx_valid` and `tx_ready` are high. While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` are held unchanged. The engine issues no buffer read until every byte of the previous word has been accepted, so back-pressure reaches the memory port directly.

Top module: `txd_engine`

## Requirements
- R1: After reset, the interrupt status register reads zero, transmit enable is off, `irq` is low, `mem_req` is low and `tx_valid` is low.
- R2: The register at offset 0x0 holds the ring base. Bits 7:0 always read zero, which forces a 256-byte-aligned ring. Writing this register points the fetch pointer at the new base.
- R3: A fetch starts only on a write to offset 0x8 with bit 6 (0x40) set while the enable bit (bit 2, value 0x04, at offset 0x4) is set. The first descriptor read appears on `mem_req` in the cycle after that write. Bit 6 of offset 0x8 reads 1 while the engine is active. A poll write without bit 6, or with enable clear, does nothing.
- R4: A descriptor is four 32-bit words at pointer +0, +4, +8 and +12: status, tag (read and ignored), buffer address, and buffer address upper word. In the status word, bit 31 is ownership (1 = engine owns), bit 30 is end-of-ring, bit 29 is first segment, bit 28 is last segment, and bits 15:0 are the byte length.
- R5: Buffer bytes leave in address order from any starting byte alignment. Within a 32-bit word, byte 0 occupies bits 7:0. Bytes are transferred only on `tx_valid && tx_ready`, and the outputs hold while stalled.
- R6: `tx_last` is high only with the final byte of a descriptor whose last-segment bit 28 is set. It stays low through a descriptor without that bit.
- R7: After a descriptor is done, its status word at offset +0 is rewritten with bit 31 cleared and every other bit unchanged. A good descriptor sets interrupt bit 2 (0x04).
- R8: A descriptor with length zero or a non-zero upper address word sends no bytes. It is still written back with ownership cleared, and it sets interrupt bit 3 (0x08).
- R9: After each descriptor the pointer moves to the ring base if bit 30 was set, and otherwise advances by 16 bytes. Processing continues while the next descriptor is owned.
- R10: Reading a descriptor with bit 31 clear sets interrupt bit 7 (0x80) and stops the engine with the pointer left on that descriptor. The engine does not restart, even if ownership is later given, until a new poll write.
- R11: Interrupt status is at offset 0xC. Writing a one to bit 2, 3 or 7 clears that bit. `irq` is high exactly while any status bit is set.
- R12: Clearing enable while a descriptor is in flight lets that descriptor finish and be written back, and then no further descriptor is fetched.
- R13: Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until the cycle with `mem_ack`. Read data is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Any interrupt status bit set |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a last-segment descriptor |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
Only three results have a fixed latency, and the bench checks each at that exact cycle:
- `mem_req` rises one cycle after the poll write.
- An interrupt bit becomes visible in the cycle after the acknowledge of its write-back.
- A one-to-clear write takes effect at the next edge, so each clear is read back one cycle later.

Frame-length results depend on memory latency and on the pace of the sink, which includes a stalling ready pattern. For these, the bench waits for the busy bit at offset 0x8 to fall. It then compares the collected bytes, the last flags, the written-back descriptors and the status register against values built from the descriptors it wrote. Checks that nothing happens watch the memory port over a fixed window.

// File: rtl/txd_pkg.sv
package txd_pkg;
  // register byte offsets
  localparam logic [3:0] OFS_BASE = 4'h0;
  localparam logic [3:0] OFS_CMD  = 4'h4;
  localparam logic [3:0] OFS_POLL = 4'h8;
  localparam logic [3:0] OFS_INT  = 4'hC;

  localparam int CMD_TXEN_BIT = 2;
  localparam int POLL_GO_BIT  = 6;

  localparam int INT_OK_BIT   = 2;
  localparam int INT_ERR_BIT  = 3;
  localparam int INT_UNAV_BIT = 7;

  // descriptor status word
  localparam int OWN_BIT = 31;
  localparam int EOR_BIT = 30;
  localparam int FS_BIT  = 29;
  localparam int LS_BIT  = 28;

  localparam int WORD_BYTES = 4;
  localparam int DESC_WORDS = 4;
  localparam int DESC_BYTES = DESC_WORDS * WORD_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC,
    ST_CHECK,
    ST_BUF,
    ST_DRAIN,
    ST_WBACK
  } txd_state_e;

  typedef struct packed {
    logic ok;
    logic err;
    logic unav;
  } txd_evt_t;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int ALIGN_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        busy,
  input  txd_evt_t    evt,
  output logic [31:0] reg_rdata,
  output logic [31:0] ring_base,
  output logic        tx_en,
  output logic        poll_go,
  output logic        base_load,
  output logic        irq
);
  localparam logic [7:0] INT_IMPL =
    8'((1 << INT_OK_BIT) | (1 << INT_ERR_BIT) | (1 << INT_UNAV_BIT));

  logic [31:0] base_q;
  logic        en_q;
  logic        base_load_q;
  logic [7:0]  ist_q;
  logic [7:0]  set_v;
  logic [7:0]  clr_v;

  logic wr_base, wr_cmd, wr_poll, wr_int;
  assign wr_base = reg_wr && (reg_addr == OFS_BASE);
  assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
  assign wr_poll = reg_wr && (reg_addr == OFS_POLL);
  assign wr_int  = reg_wr && (reg_addr == OFS_INT);

  always_comb begin
    set_v = '0;
    set_v[INT_OK_BIT]   = evt.ok;
    set_v[INT_ERR_BIT]  = evt.err;
    set_v[INT_UNAV_BIT] = evt.unav;
    clr_v = wr_int ? (reg_wdata[7:0] & INT_IMPL) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q      <= '0;
      en_q        <= 1'b0;
      base_load_q <= 1'b0;
      ist_q       <= '0;
    end else begin
      base_load_q <= wr_base;
      if (wr_base) base_q <= {reg_wdata[31:ALIGN_W], {ALIGN_W{1'b0}}};
      if (wr_cmd)  en_q   <= reg_wdata[CMD_TXEN_BIT];
      ist_q <= (ist_q & ~clr_v) | set_v;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_BASE: reg_rdata = base_q;
      OFS_CMD:  reg_rdata[CMD_TXEN_BIT] = en_q;
      OFS_POLL: reg_rdata[POLL_GO_BIT] = busy;
      OFS_INT:  reg_rdata[7:0] = ist_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign ring_base = base_q;
  assign tx_en     = en_q;
  assign base_load = base_load_q;
  assign poll_go   = wr_poll && reg_wdata[POLL_GO_BIT] && en_q;
  assign irq       = |ist_q;
endmodule

// File: rtl/txd_stream.sv
module txd_stream #(
  parameter int BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld,
  input  logic [8*BYTES-1:0]   ld_word,
  input  logic [$clog2(BYTES)-1:0]   ld_ofs,
  input  logic [$clog2(BYTES+1)-1:0] ld_cnt,
  input  logic                 ld_last,
  input  logic                 tx_ready,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic                 tx_last,
  output logic                 empty
);
  localparam int IW = $clog2(BYTES);
  localparam int CW = $clog2(BYTES + 1);

  logic [8*BYTES-1:0] word_q;
  logic [IW-1:0]      idx_q;
  logic [CW-1:0]      cnt_q;
  logic               last_q;
  logic [7:0]         lane [BYTES];

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane[g] = word_q[8*g +: 8];
  end

  assign empty    = (cnt_q == '0);
  assign tx_valid = !empty;
  assign tx_data  = lane[idx_q];
  assign tx_last  = last_q && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (ld) begin
      word_q <= ld_word;
      idx_q  <= ld_ofs;
      cnt_q  <= ld_cnt;
      last_q <= ld_last;
    end else if (tx_valid && tx_ready) begin
      idx_q <= idx_q + IW'(1);
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll_go,
  input  logic        base_load,
  input  logic [31:0] ring_base,
  input  logic        tx_en,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        strm_empty,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        ld,
  output logic [1:0]  ld_ofs,
  output logic [2:0]  ld_cnt,
  output logic        ld_last,
  output txd_evt_t    evt,
  output logic        busy
);
  localparam logic [31:0] OWN_MASK = 32'(1) << OWN_BIT;
  localparam int          PAD_W    = LEN_W - 3;

  txd_state_e       state_q;
  logic [1:0]       widx_q;
  logic [31:0]      cur_q;
  logic [31:0]      stat_q;
  logic [31:0]      lo_q;
  logic [31:0]      hi_q;
  logic [31:0]      bptr_q;
  logic [LEN_W-1:0] remain_q;
  logic             err_q;

  logic [2:0]       avail;
  logic             fin;
  logic [2:0]       take;
  logic [LEN_W-1:0] len;

  assign len   = stat_q[LEN_W-1:0];
  assign avail = 3'd4 - {1'b0, bptr_q[1:0]};
  assign fin   = remain_q <= {{PAD_W{1'b0}}, avail};
  assign take  = fin ? remain_q[2:0] : avail;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = stat_q & ~OWN_MASK;
    case (state_q)
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + {28'd0, widx_q, 2'b00};
      end
      ST_BUF: begin
        mem_req  = strm_empty;
        mem_addr = {bptr_q[31:2], 2'b00};
      end
      ST_WBACK: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
      end
      default: ;
    endcase
  end

  assign ld      = (state_q == ST_BUF) && mem_req && mem_ack;
  assign ld_ofs  = bptr_q[1:0];
  assign ld_cnt  = take;
  assign ld_last = fin && stat_q[LS_BIT];
  assign busy    = (state_q != ST_IDLE);

  always_comb begin
    evt.ok   = (state_q == ST_WBACK) && mem_ack && !err_q;
    evt.err  = (state_q == ST_WBACK) && mem_ack && err_q;
    evt.unav = (state_q == ST_DESC) && mem_ack && (widx_q == 2'd0)
               && !mem_rdata[OWN_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      widx_q   <= '0;
      cur_q    <= '0;
      stat_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      bptr_q   <= '0;
      remain_q <= '0;
      err_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (poll_go) begin
            state_q <= ST_DESC;
            widx_q  <= '0;
          end
        end
        ST_DESC: begin
          if (mem_ack) begin
            widx_q <= widx_q + 2'd1;
            case (widx_q)
              2'd0: begin
                stat_q <= mem_rdata;
                if (!mem_rdata[OWN_BIT]) begin
                  state_q <= ST_IDLE;
                  widx_q  <= '0;
                end
              end
              2'd2: lo_q <= mem_rdata;
              2'd3: begin
                hi_q    <= mem_rdata;
                state_q <= ST_CHECK;
              end
              default: ;
            endcase
          end
        end
        ST_CHECK: begin
          if ((len == '0) || (hi_q != '0)) begin
            err_q   <= 1'b1;
            state_q <= ST_WBACK;
          end else begin
            err_q    <= 1'b0;
            bptr_q   <= lo_q;
            remain_q <= len;
            state_q  <= ST_BUF;
          end
        end
        ST_BUF: begin
          if (ld) begin
            bptr_q   <= bptr_q + {29'd0, take};
            remain_q <= remain_q - {{PAD_W{1'b0}}, take};
            if (fin) state_q <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (strm_empty) state_q <= ST_WBACK;
        end
        ST_WBACK: begin
          if (mem_ack) begin
            cur_q   <= stat_q[EOR_BIT] ? ring_base : cur_q + 32'(DESC_BYTES);
            widx_q  <= '0;
            state_q <= tx_en ? ST_DESC : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (base_load) cur_q <= ring_base;
    end
  end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int ALIGN_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [31:0] ring_base;
  logic        tx_en, poll_go, base_load, busy;
  txd_evt_t    evt;
  logic        ld, ld_last, strm_empty;
  logic [1:0]  ld_ofs;
  logic [2:0]  ld_cnt;

  txd_regs #(.ALIGN_W(ALIGN_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .evt(evt), .reg_rdata(reg_rdata),
    .ring_base(ring_base), .tx_en(tx_en), .poll_go(poll_go),
    .base_load(base_load), .irq(irq)
  );

  txd_ctrl #(.LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .poll_go(poll_go), .base_load(base_load),
    .ring_base(ring_base), .tx_en(tx_en), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .strm_empty(strm_empty), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ld(ld),
    .ld_ofs(ld_ofs), .ld_cnt(ld_cnt), .ld_last(ld_last), .evt(evt),
    .busy(busy)
  );

  txd_stream #(.BYTES(WORD_BYTES)) i_stream (
    .clk(clk), .rst_n(rst_n), .ld(ld), .ld_word(mem_rdata), .ld_ofs(ld_ofs),
    .ld_cnt(ld_cnt), .ld_last(ld_last), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .empty(strm_empty)
  );
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        tx_valid,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        tx_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
    && $stable(mem_wdata)); // R13

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)
    && $stable(tx_last)); // R5

  AST_NO_READ_WHILE_STREAMING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(mem_req && !mem_we)); // R5

  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !mem_wdata[31]); // R7

  AST_WB_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr[3:0] == 4'h0); // R9
endmodule

bind txd_engine txd_engine_chk i_chk (.*);

// File: tb/test_txd_engine.sv
module test_txd_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_last, tx_ready;
  logic [7:0]  tx_data;

  always #2 clk = ~clk;

  txd_engine i_txd_engine (.*);

  localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000;
  localparam logic [31:0] FS  = 32'h2000_0000, LS  = 32'h1000_0000;

  int nchk = 0, nerr = 0;
  logic [31:0] mem [0:1023];
  logic        ack_q = 1'b0;
  logic [31:0] rdata_q = '0;
  assign mem_ack   = ack_q;
  assign mem_rdata = rdata_q;

  int rd_cnt = 0, viol = 0;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  always @(posedge clk) begin
    if (!rst_n) ack_q <= 1'b0;
    else if (mem_req && !ack_q) begin
      ack_q <= 1'b1;
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else rdata_q <= mem[mem_addr[11:2]];
    end else ack_q <= 1'b0;
    if (rst_n && mem_req && mem_ack) rd_cnt <= rd_cnt + 1;
    if (rst_n && pend && mem_req && mem_addr != pend_addr) viol <= viol + 1;
    pend      <= rst_n && mem_req && !mem_ack;
    pend_addr <= mem_addr;
  end

  logic [7:0] got_d [0:63];
  logic       got_l [0:63];
  int         ngot = 0;
  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready && ngot < 64) begin
      got_d[ngot] <= tx_data;
      got_l[ngot] <= tx_last;
      ngot <= ngot + 1;
    end
  end

  logic stall = 1'b0;
  int   cyc = 0;
  always @(negedge clk) begin
    cyc <= cyc + 1;
    tx_ready <= stall ? (cyc % 3 != 2) : 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(4'h8, v);
      if (!v[6]) break;
    end
  endtask

  task automatic put_desc(input int a, input logic [31:0] st, input logic [31:0] lo,
                          input logic [31:0] hi);
    mem[a/4] = st; mem[a/4+1] = 32'hDEAD_BEEF; mem[a/4+2] = lo; mem[a/4+3] = hi;
  endtask

  task automatic put_byte(input int a, input logic [7:0] v);
    mem[a/4][8*(a%4) +: 8] = v;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'hC, v); chk("R1 int status", v, 32'h0);
    rd(4'h4, v); chk("R1 enable", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 mem_req", {31'd0, mem_req}, 32'h0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'h0);
  endtask

  task automatic t_base();
    logic [31:0] v;
    wr(4'h0, 32'h0000_12FF);
    rd(4'h0, v); chk("R2 base aligned", v, 32'h0000_1200);
    wr(4'h0, 32'h0000_0100);
  endtask

  task automatic t_poll_gate();
    int c0;
    put_desc(32'h100, OWN | EOR | FS | LS | 32'd6, 32'h401, 32'h0);
    for (int i = 0; i < 6; i++) put_byte(32'h401 + i, 8'hA1 + 8'(i));
    c0 = rd_cnt;
    wr(4'h8, 32'h40);
    repeat (10) @(negedge clk);
    chk("R3 poll with enable off", rd_cnt - c0, 0);
    wr(4'h4, 32'h04);
    wr(4'h8, 32'h3F);
    repeat (10) @(negedge clk);
    chk("R3 poll without go bit", rd_cnt - c0, 0);
    chk("R3 no bytes", ngot, 0);
  endtask

  task automatic t_single();
    logic [31:0] v;
    ngot = 0;
    wr(4'h8, 32'h40);
    chk("R3 mem_req one cycle after poll", {31'd0, mem_req}, 32'h1);
    rd(4'h8, v); chk("R3 busy bit", v, 32'h40);
    wait_idle();
    chk("R5 byte count", ngot, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R4 R5 byte from buffer address", {24'd0, got_d[i]}, 32'hA1 + i);
      chk("R6 last flag", {31'd0, got_l[i]}, (i == 5) ? 32'h1 : 32'h0);
    end
    chk("R7 write-back", mem[32'h100/4], EOR | FS | LS | 32'd6);
    rd(4'hC, v); chk("R10 R7 int after wrap to unowned", v, 32'h84);
    chk("R11 irq set", {31'd0, irq}, 32'h1);
    wr(4'hC, 32'h04);
    rd(4'hC, v); chk("R11 clear ok bit", v, 32'h80);
    wr(4'hC, 32'h80);
    rd(4'hC, v); chk("R11 clear unav bit", v, 32'h0);
    chk("R11 irq low", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_resume();
    logic [31:0] v;
    int c0;
    ngot = 0;
    mem[32'h100/4] = OWN | EOR | FS | LS | 32'd1;
    c0 = rd_cnt;
    repeat (20) @(negedge clk);
    chk("R10 no restart without poll", rd_cnt - c0, 0);
    wr(4'h8, 32'h40);
    wait_idle();
    chk("R10 resumes at same descriptor", ngot, 1);
    chk("R10 byte", {24'd0, got_d[0]}, 32'hA1);
    rd(4'hC, v); chk("R10 status", v, 32'h84);
    wr(4'hC, 32'h84);
  endtask

  task automatic t_ring();
    logic [31:0] v;
    ngot = 0; stall = 1'b1;
    wr(4'h0, 32'h300);
    put_desc(32'h300, OWN | FS | 32'd5, 32'h500, 32'h0);
    put_desc(32'h310, OWN | LS | 32'd3, 32'h512, 32'h0);
    put_desc(32'h320, OWN | EOR | FS | LS | 32'd4, 32'h520, 32'h1);
    put_desc(32'h330, OWN | FS | LS | 32'd2, 32'h520, 32'h0);
    for (int i = 0; i < 5; i++) put_byte(32'h500 + i, 8'h10 + 8'(i));
    for (int i = 0; i < 3; i++) put_byte(32'h512 + i, 8'h20 + 8'(i));
    wr(4'h8, 32'h40);
    wait_idle();
    stall = 1'b0;
    chk("R9 R8 byte count", ngot, 8);
    for (int i = 0; i < 8; i++) begin
      chk("R5 stalled bytes", {24'd0, got_d[i]}, (i < 5) ? 32'h10 + i : 32'h20 + i - 5);
      chk("R6 last only at LS end", {31'd0, got_l[i]}, (i == 7) ? 32'h1 : 32'h0);
    end
    chk("R9 d0 written back", mem[32'h300/4], FS | 32'd5);
    chk("R9 d1 written back", mem[32'h310/4], LS | 32'd3);
    chk("R8 d2 written back", mem[32'h320/4], EOR | FS | LS | 32'd4);
    chk("R9 wrap skips d3", mem[32'h330/4], OWN | FS | LS | 32'd2);
    rd(4'hC, v); chk("R8 R9 int status", v, 32'h8C);
    wr(4'hC, 32'h8C);
  endtask

  task automatic t_zero_len();
    logic [31:0] v;
    ngot = 0;
    wr(4'h0, 32'h600);
    put_desc(32'h600, OWN | EOR | FS | LS, 32'h500, 32'h0);
    wr(4'h8, 32'h40);
    wait_idle();
    chk("R8 zero length sends nothing", ngot, 0);
    chk("R8 zero length write-back", mem[32'h600/4], EOR | FS | LS);
    rd(4'hC, v); chk("R8 error bit", v, 32'h88);
    wr(4'hC, 32'h88);
  endtask

  task automatic t_enable_off();
    logic [31:0] v;
    int c0;
    ngot = 0;
    wr(4'h0, 32'h700);
    put_desc(32'h700, OWN | FS | LS | 32'd2, 32'h540, 32'h0);
    put_desc(32'h710, OWN | EOR | FS | LS | 32'd2, 32'h544, 32'h0);
    mem[32'h540/4] = 32'h0000_3231;
    mem[32'h544/4] = 32'h0000_3433;
    wr(4'h8, 32'h40);
    wr(4'h4, 32'h00);
    wait_idle();
    chk("R12 first finishes", ngot, 2);
    chk("R12 first written back", mem[32'h700/4], FS | LS | 32'd2);
    chk("R12 second untouched", mem[32'h710/4], OWN | EOR | FS | LS | 32'd2);
    rd(4'hC, v); chk("R12 status", v, 32'h04);
    c0 = rd_cnt;
    wr(4'h4, 32'h04);
    repeat (20) @(negedge clk);
    chk("R3 enable alone does not start", rd_cnt - c0, 0);
    wr(4'h8, 32'h40);
    wait_idle();
    chk("R12 second sent after poll", ngot, 4);
    chk("R12 second byte", {24'd0, got_d[3]}, 32'h34);
    rd(4'hC, v); chk("R12 R10 status", v, 32'h84);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired (all requirements)");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_poll_gate();
    t_single();
    t_resume();
    t_ring();
    t_zero_len();
    t_enable_off();
    chk("R13 request held until ack", viol, 0);
    summary();
    $finish;
  end
endmodule